// File: doc/BRIEF.md
# Six-Step Center-Aligned PWM Generator

This block drives three half-bridges from one up-down counter. Each phase pair has a compare value that sets a pulse centred on the counter peak. The high-side output (even channel) and the low-side output (odd channel) of each pair are complementary, with a programmable dead band between them. A marker pulse leaves the block each time the counter reaches its minimum, so that sampling logic elsewhere can align to the start of the period.

Six-step commutation is built from a per-channel override. Any channel can be pinned to a fixed level while the other channels keep following the PWM. The override word is staged in a shadow register. It moves into effect on a commutation trigger from hardware or on a software sync strobe, so the next sector's pattern can be prepared ahead of time and applied at the exact commutation instant. Compare values are also staged, and they move into effect only at the counter minimum.

Top module: `sixstep_pwm`

## Requirements
- R1: The counter runs 0, 1, …, HALF_PERIOD, HALF_PERIOD−1, …, 1 and then repeats, so one period is 2·HALF_PERIOD cycles. `init_trig` is high for exactly the one cycle in which the counter is 0. That includes the first cycle after reset. Writes and sync strobes never disturb the counter.
- R2: The reference level of pair i is high while counter ≥ active compare C. It is therefore high for 2·(HALF_PERIOD−C)+1 cycles per period. C = 0 keeps it high at all times, and C > HALF_PERIOD keeps it low at all times.
- R3: `pwm_out[2i]` is the high side and `pwm_out[2i+1]` the low side of pair i (pair 0 = phase A, 1 = B, 2 = C). After each reference edge, the side being switched off drops one cycle later. The side being switched on rises DEAD_TICKS cycles after that. A high reference time H therefore gives a high-side pulse of max(H−DEAD_TICKS, 0) cycles, and a low time L gives a low-side pulse of max(L−DEAD_TICKS, 0) cycles.
- R4: While neither channel of a pair is overridden, its two outputs are never high in the same cycle.
- R5: A compare write (`cmp_wr`, pair index `cmp_sel`, value `cmp_data`) only fills a shadow register. The shadow is copied into the active compare at the clock edge that leaves counter value 0. An index of NPAIR or above is ignored.
- R6: In the override word, bit k (k = 0…5) set forces `pwm_out[k]` to the value of bit 8+k. Bit k clear leaves channel k under PWM control.
- R7: `ovr_wr` only loads the override shadow. The outputs do not change until a sync strobe arrives. After the strobe they show the shadow from the cycle after it. A shadow write in the same cycle as a strobe is not part of that load.
- R8: `hw_sync` and `sw_sync` each load the override shadow on their own, and both together act as one strobe.
- R9: After reset all outputs are low: every channel is overridden to 0 in both the active and the shadow override. The active and shadow compares hold HALF_PERIOD+1, which keeps the reference low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_wr | input | 1 | Write strobe for a compare shadow |
| cmp_sel | input | $clog2(NPAIR) | Pair index for the compare write |
| cmp_data | input | CNT_W | Compare value |
| ovr_wr | input | 1 | Write strobe for the override shadow |
| ovr_data | input | 16 | Override word: enables [5:0], levels [13:8] |
| hw_sync | input | 1 | Commutation trigger that loads the override |
| sw_sync | input | 1 | Software strobe that loads the override |
| pwm_out | output | 2·NPAIR | Gate outputs; even index high side, odd index low side |
| init_trig | output | 1 | High during the counter-minimum cycle |

## Verification
The assertions assume that reset is applied from time zero and that the compare and override strobes are synchronous single-cycle pulses. They also assume the dead-time value is at least one cycle, so that a rising side is always preceded by a cycle in which its partner is already low. The bench drives every strobe on the falling clock edge for exactly one cycle. It runs a reduced period (HALF_PERIOD 20, DEAD_TICKS 3) so that full-period pulse counts, including a pulse no longer than the dead band, fit within a short run. A cycle-by-cycle model in the bench predicts every output from the requirement rules, and directed pulse counts confirm the width formulas.

// File: rtl/sixstep_pwm.sv
module sixstep_pwm #(
  parameter int CNT_W       = 16,
  parameter int HALF_PERIOD = 2000,
  parameter int DEAD_TICKS  = 40,
  parameter int NPAIR       = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    cmp_wr,
  input  logic [((NPAIR > 1) ? $clog2(NPAIR) : 1)-1:0] cmp_sel,
  input  logic [CNT_W-1:0]                        cmp_data,
  input  logic                                    ovr_wr,
  input  logic [15:0]                             ovr_data,
  input  logic                                    hw_sync,
  input  logic                                    sw_sync,
  output logic [2*NPAIR-1:0]                      pwm_out,
  output logic                                    init_trig
);

  localparam int NCH     = 2 * NPAIR;
  localparam int LVL_LSB = 8;
  localparam int DT_W    = $clog2(DEAD_TICKS + 1);
  localparam logic [CNT_W-1:0] TOP     = CNT_W'(HALF_PERIOD);
  localparam logic [CNT_W-1:0] CMP_OFF = CNT_W'(HALF_PERIOD + 1);
  localparam logic [DT_W-1:0]  DT_MAX  = DT_W'(DEAD_TICKS);
  localparam logic [15:0] USED_MASK = 16'(((1 << NCH) - 1) | (((1 << NCH) - 1) << LVL_LSB));

  logic [CNT_W-1:0]            cnt;
  logic                        cnt_up;
  logic [NPAIR-1:0][CNT_W-1:0] cmp_sh, cmp_act;
  logic [NCH-1:0]              ovr_en, ovr_lvl, ovr_en_sh, ovr_lvl_sh;
  logic [NCH-1:0]              pwm_dt;
  logic                        at_min;
  logic                        unused_ovr_bits;

  assign at_min          = (cnt == '0);
  assign init_trig       = at_min;
  assign unused_ovr_bits = ^(ovr_data & ~USED_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else if (cnt_up) begin
      if (cnt == TOP) begin
        cnt    <= TOP - 1'b1;
        cnt_up <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (at_min) begin
      cnt    <= CNT_W'(1);
      cnt_up <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh  <= {NPAIR{CMP_OFF}};
      cmp_act <= {NPAIR{CMP_OFF}};
    end else begin
      if (cmp_wr && (int'(cmp_sel) < NPAIR))
        cmp_sh[cmp_sel] <= cmp_data;
      if (at_min)
        cmp_act <= cmp_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_en_sh  <= '1;
      ovr_lvl_sh <= '0;
      ovr_en     <= '1;
      ovr_lvl    <= '0;
    end else begin
      if (ovr_wr) begin
        ovr_en_sh  <= ovr_data[NCH-1:0];
        ovr_lvl_sh <= ovr_data[LVL_LSB +: NCH];
      end
      if (hw_sync || sw_sync) begin
        ovr_en  <= ovr_en_sh;
        ovr_lvl <= ovr_lvl_sh;
      end
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic            ref_lvl, ref_q, settled;
    logic [DT_W-1:0] dt_cnt;

    assign ref_lvl = (cnt >= cmp_act[p]);
    assign settled = (dt_cnt == DT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q  <= 1'b0;
        dt_cnt <= DT_MAX;
      end else if (ref_lvl != ref_q) begin
        ref_q  <= ref_lvl;
        dt_cnt <= '0;
      end else if (!settled) begin
        dt_cnt <= dt_cnt + 1'b1;
      end
    end

    assign pwm_dt[2*p]   = ref_q & settled;
    assign pwm_dt[2*p+1] = ~ref_q & settled;
  end

  assign pwm_out = (ovr_en & ovr_lvl) | (~ovr_en & pwm_dt);

endmodule

// File: rtl/sixstep_pwm_chk.sv
module sixstep_pwm_chk #(
  parameter int CNT_W       = 16,
  parameter int HALF_PERIOD = 2000,
  parameter int NPAIR       = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        hw_sync,
  input logic                        sw_sync,
  input logic                        init_trig,
  input logic [2*NPAIR-1:0]          pwm_out,
  input logic [CNT_W-1:0]            cnt,
  input logic [NPAIR-1:0][CNT_W-1:0] cmp_act,
  input logic [2*NPAIR-1:0]          ovr_en,
  input logic [2*NPAIR-1:0]          ovr_lvl
);

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(HALF_PERIOD));

  a_r1_init_single: assert property (@(posedge clk) disable iff (!rst_n)
    init_trig |=> !init_trig);

  a_r5_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(cmp_act));

  a_r7_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_sync || sw_sync) |=> ($stable(ovr_en) && $stable(ovr_lvl)));

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair_chk
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovr_en[2*p] || ovr_en[2*p+1]) |-> !(pwm_out[2*p] && pwm_out[2*p+1]));

    a_r3_hs_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en[2*p] && !ovr_en[2*p+1] && $stable(ovr_en) && $rose(pwm_out[2*p]))
        |-> !$past(pwm_out[2*p+1]));

    a_r3_ls_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en[2*p] && !ovr_en[2*p+1] && $stable(ovr_en) && $rose(pwm_out[2*p+1]))
        |-> !$past(pwm_out[2*p]));
  end

  logic unused_lvl;
  assign unused_lvl = ^ovr_lvl;

endmodule

bind sixstep_pwm sixstep_pwm_chk #(
  .CNT_W(CNT_W), .HALF_PERIOD(HALF_PERIOD), .NPAIR(NPAIR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_sync(hw_sync), .sw_sync(sw_sync),
  .init_trig(init_trig), .pwm_out(pwm_out), .cnt(cnt), .cmp_act(cmp_act),
  .ovr_en(ovr_en), .ovr_lvl(ovr_lvl)
);

// File: tb/sixstep_pwm_bench.sv
module sixstep_pwm_bench;
  localparam int HP = 20;
  localparam int DT = 3;
  localparam int PER = 2 * HP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_wr = 1'b0;
  logic [1:0]  cmp_sel = '0;
  logic [15:0] cmp_data = '0;
  logic        ovr_wr = 1'b0;
  logic [15:0] ovr_data = '0;
  logic        hw_sync = 1'b0;
  logic        sw_sync = 1'b0;
  logic [5:0]  pwm_out;
  logic        init_trig;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_tag = "R9";

  sixstep_pwm #(.CNT_W(16), .HALF_PERIOD(HP), .DEAD_TICKS(DT), .NPAIR(3)) u_sixstep_pwm (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_sel(cmp_sel), .cmp_data(cmp_data),
    .ovr_wr(ovr_wr), .ovr_data(ovr_data), .hw_sync(hw_sync), .sw_sync(sw_sync),
    .pwm_out(pwm_out), .init_trig(init_trig)
  );

  always #2 clk = ~clk;

  // reference model built from the requirement rules
  int m_cnt, m_up;
  int m_cmp_sh[3], m_cmp_act[3];
  logic [5:0] m_en, m_lvl, m_en_sh, m_lvl_sh;
  logic [DT:0] hist[3];
  logic [6:0] exp_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1;
      for (int i = 0; i < 3; i++) begin
        m_cmp_sh[i] = HP + 1; m_cmp_act[i] = HP + 1; hist[i] = '0;
      end
      m_en = '1; m_lvl = '0; m_en_sh = '1; m_lvl_sh = '0;
      exp_q.delete();
    end else begin
      logic [5:0] e;
      for (int i = 0; i < 3; i++)
        hist[i] = {hist[i][DT-1:0], (m_cnt >= m_cmp_act[i])};
      if (m_cnt == 0)
        for (int i = 0; i < 3; i++) m_cmp_act[i] = m_cmp_sh[i];
      if (cmp_wr && cmp_sel < 3) m_cmp_sh[cmp_sel] = int'(cmp_data);
      if (hw_sync || sw_sync) begin m_en = m_en_sh; m_lvl = m_lvl_sh; end
      if (ovr_wr) begin m_en_sh = ovr_data[5:0]; m_lvl_sh = ovr_data[13:8]; end
      if (m_up == 1) begin
        if (m_cnt == HP) begin m_cnt = HP - 1; m_up = 0; end else m_cnt++;
      end else begin
        if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end else m_cnt--;
      end
      for (int i = 0; i < 3; i++) begin
        e[2*i]   = &hist[i];
        e[2*i+1] = ~|hist[i];
      end
      e = (m_en & m_lvl) | (~m_en & e);
      exp_q.push_back({(m_cnt == 0), e});
    end
  end

  // monitor: pop and compare every cycle
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0 && !done) begin
      logic [6:0] x;
      x = exp_q.pop_front();
      checks++;
      if (pwm_out !== x[5:0] || init_trig !== x[6]) begin
        fails++;
        $display("FAIL %s model: pwm=%b init=%b expected pwm=%b init=%b",
                 cur_tag, pwm_out, init_trig, x[5:0], x[6]);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_write(int p, int v);
    @(negedge clk); cmp_wr = 1'b1; cmp_sel = 2'(p); cmp_data = 16'(v);
    @(negedge clk); cmp_wr = 1'b0;
  endtask

  task automatic ovr_write(logic [15:0] v);
    @(negedge clk); ovr_wr = 1'b1; ovr_data = v;
    @(negedge clk); ovr_wr = 1'b0;
  endtask

  task automatic sync_pulse(bit hw, bit sw);
    @(negedge clk); hw_sync = hw; sw_sync = sw;
    @(negedge clk); hw_sync = 1'b0; sw_sync = 1'b0;
  endtask

  task automatic wait_min();
    do @(negedge clk); while (!init_trig);
  endtask

  task automatic count_period(output int c[6], output int both);
    both = 0;
    for (int k = 0; k < 6; k++) c[k] = 0;
    for (int n = 0; n < PER; n++) begin
      if (n > 0) @(negedge clk);
      for (int k = 0; k < 6; k++) c[k] += int'(pwm_out[k]);
      for (int p = 0; p < 3; p++) both += int'(pwm_out[2*p] & pwm_out[2*p+1]);
    end
  endtask

  task automatic check_counts(string tag, int e0, int e1, int e2, int e3, int e4, int e5);
    int c[6]; int both; int e[6];
    e = '{e0, e1, e2, e3, e4, e5};
    count_period(c, both);
    for (int k = 0; k < 6; k++) check($sformatf("%s ch%0d high cycles", tag, k), c[k], e[k]);
    check("R4 both sides high", both, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    check("R9 outputs low in reset", int'(pwm_out), 0);
    check("R1 init_trig in reset", int'(init_trig), 1);
    rst_n = 1'b1;
    @(negedge clk);

    cur_tag = "R7";
    ovr_write(16'h0000);
    repeat (5) @(negedge clk);
    check("R7 shadow not applied without sync", int'(pwm_out), 0);

    cur_tag = "R5";
    cmp_write(0, 5);
    cmp_write(1, 12);
    cmp_write(2, 19);
    cur_tag = "R8";
    sync_pulse(1'b0, 1'b1);
    cur_tag = "R3";
    wait_min(); wait_min();
    check_counts("R2 R3 widths", 28, 6, 14, 20, 0, 34);

    cur_tag = "R5";
    cmp_write(0, HP + 1);
    cmp_write(1, 0);
    cmp_write(3, 7);
    cur_tag = "R2";
    wait_min(); wait_min();
    check_counts("R2 R5 extremes", 0, 40, 40, 0, 0, 34);

    cur_tag = "R7";
    ovr_write(16'h020F);
    repeat (10) @(negedge clk);
    check("R7 ch2 still PWM before sync", int'(pwm_out[2]), 1);
    cur_tag = "R6";
    sync_pulse(1'b1, 1'b0);
    check("R8 hw_sync applies ch2 force", int'(pwm_out[2]), 0);
    check("R6 ch1 forced high", int'(pwm_out[1]), 1);
    wait_min();
    check_counts("R6 override pattern", 0, 40, 0, 0, 0, 34);

    cur_tag = "R8";
    ovr_write(16'h003F);
    sync_pulse(1'b1, 1'b1);
    check("R8 both strobes load all-off", int'(pwm_out), 0);

    cur_tag = "R7";
    @(negedge clk); ovr_wr = 1'b1; ovr_data = 16'h0000; sw_sync = 1'b1;
    @(negedge clk); ovr_wr = 1'b0; sw_sync = 1'b0;
    check("R7 same-cycle write not loaded", int'(pwm_out), 0);
    sync_pulse(1'b0, 1'b1);
    wait_min();
    check_counts("R6 release to PWM", 0, 40, 40, 0, 0, 34);

    cur_tag = "R1";
    wait_min();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!init_trig);
    check("R1 init_trig spacing", gap, PER);

    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule